// File: doc/BRIEF.md
# Serial I/Q Output Port

This block turns one complex baseband sample per word period into a bit-serial stream. It drives a single data line, a bit clock and a frame-sync line. A frame carries the in-phase word and then the quadrature word, each 16 or 24 bits wide and sent MSB first. Up to two gain-control bytes may follow: an attenuation byte and a signal-strength/status byte. The data line can also carry its own byte framing, with a start bit and a stop bit around each byte and a run of idle-high bits after the frame. In that case the separate sync line is not used.

An upstream decimator presents a sample with a one-cycle `smp_valid` pulse. If the port is idle, it captures the sample together with every configuration input and starts the frame on the next cycle. Configuration applied later has no effect until the next accepted sample. If a sample arrives while a frame is still running, the port drops it and sets a sticky overrun flag. The controller holds four states:

- **IDLE**: waits for a sample.
- **SYNC**: one bit period with frame sync active, used in dedicated-sync mode only.
- **DATA**: shifts out the payload bits.
- **GAP**: idle-high tail of an embedded-sync frame.

The transitions are:

- IDLE→SYNC on acceptance with dedicated sync.
- IDLE→DATA on acceptance with embedded sync.
- SYNC→DATA at the end of the sync period.
- DATA→IDLE after the last payload bit with dedicated sync.
- DATA→GAP after the last stop bit with embedded sync.
- GAP→IDLE after the last idle period.

Top module: `iq_serial_tx`

## Requirements
- R1: A frame sends the I word and then the Q word, both MSB first. With `cfg_wide`=0 the words are bits [15:0] of `smp_i`/`smp_q`; with `cfg_wide`=1 they are all 24 bits.
- R2: With `cfg_gain_en`=1 and `cfg_gain_alt`=0, the attenuation byte and then the strength byte follow the Q word, each MSB first.
- R3: With `cfg_gain_en`=1 and `cfg_gain_alt`=1, one gain byte follows Q. The first such frame after reset carries the attenuation byte, and later ones alternate with the strength byte.
- R4: In dedicated-sync mode (`cfg_embed_sync`=0), a frame is one sync bit period followed by the payload bits. Sync is active only in that period. The payload is 32, 48 or 40 bits for a 16-bit word with no gain bytes, both bytes or one alternating byte, and 64, 56 or 48 bits for a 24-bit word in the order both, alternating, none. `ser_data_oe` is 0 during the sync period and while idle.
- R5: With `cfg_fs_long`=1 in dedicated-sync mode, frame sync stays active from the sync period through the last payload bit.
- R6: In embedded-sync mode, each payload byte is sent as a 0 start bit, 8 data bits MSB first and a 1 stop bit. Nine idle-high periods follow, so a frame lasts 49/69/59 (16-bit) or 69/89/79 (24-bit) periods for none/both/alternating gain bytes. While idle the data line is driven high.
- R7: In embedded-sync mode `ser_fs` is held 0, and `ser_fs_oe` is the inverse of `cfg_fs_hiz`.
- R8: A bit period lasts 2·`cfg_div` clock cycles, with a divider of 0 treated as 1. The uninverted bit clock is high for the first half and low for the second, so data changes with its rising edge.
- R9: `cfg_clk_inv`=1 inverts `ser_clk`. `cfg_fs_inv`=1 inverts the dedicated frame-sync level, making active low and inactive high.
- R10: A sample presented while the port is not idle is dropped and sets `overrun`, which stays set until reset. The frame in progress is unchanged.
- R11: A sample is accepted when it is presented while the port is idle. The frame starts on the next cycle, using the sample and configuration values captured at acceptance.
- R12: After reset, `overrun`=0, `ser_data_oe`=0, `ser_fs`=0 and `ser_fs_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle sample strobe |
| smp_i | input | 24 | In-phase sample |
| smp_q | input | 24 | Quadrature sample |
| agc_atten | input | 8 | Attenuation byte |
| agc_rssi | input | 8 | Signal-strength/status byte |
| cfg_wide | input | 1 | 0: 16-bit words, 1: 24-bit words |
| cfg_gain_en | input | 1 | Append gain bytes |
| cfg_gain_alt | input | 1 | One alternating gain byte per frame |
| cfg_embed_sync | input | 1 | Start/stop framing on the data line |
| cfg_clk_inv | input | 1 | Invert bit clock |
| cfg_fs_inv | input | 1 | Invert frame sync |
| cfg_fs_long | input | 1 | Sync active for the whole frame |
| cfg_fs_hiz | input | 1 | Release sync line in embedded mode |
| cfg_div | input | 8 | Bit clock divider |
| ser_clk | output | 1 | Bit clock |
| ser_data | output | 1 | Serial data |
| ser_data_oe | output | 1 | Data line drive enable |
| ser_fs | output | 1 | Frame sync |
| ser_fs_oe | output | 1 | Frame sync drive enable |
| overrun | output | 1 | Sticky dropped-sample flag |

## Verification
The assertions assume that `smp_valid` is a single-cycle pulse and that configuration inputs may change at any time, including mid-frame. They do not assume the divider is in range. The stimulus respects the single-cycle pulse: it raises `smp_valid` for exactly one cycle. Right after each acceptance it deliberately scrambles every configuration and sample input. It presents the next sample only once the line has returned to idle, except in the one dropped-sample case, where the overrun property is expected to fire.

// File: rtl/iq_ser_pkg.sv
package iq_ser_pkg;
    localparam int SMP_W   = 24;
    localparam int PAY_W   = 64;
    localparam int NB_W    = $clog2(PAY_W / 8 + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } ser_state_e;

    typedef struct packed {
        logic wide;
        logic gain_en;
        logic gain_alt;
        logic embed;
        logic clk_inv;
        logic fs_inv;
        logic fs_long;
        logic fs_hiz;
    } ser_cfg_t;
endpackage

// File: rtl/iq_ser_clkgen.sv
module iq_ser_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             bit_end,
    output logic             clk_hi
);
    localparam int PH_W = DIV_W + 1;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] half;
    logic [PH_W-1:0] last;

    always_comb begin
        half = (div == '0) ? PH_W'(1) : PH_W'(div);
        last = PH_W'((32'(half) << 1) - 32'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (restart || phase == last)
            phase <= '0;
        else
            phase <= phase + PH_W'(1);
    end

    assign bit_end = (phase == last);
    assign clk_hi  = (phase < half);
endmodule

// File: rtl/iq_ser_pack.sv
module iq_ser_pack
    import iq_ser_pkg::*;
(
    input  logic [SMP_W-1:0] i_word,
    input  logic [SMP_W-1:0] q_word,
    input  logic [7:0]       atten,
    input  logic [7:0]       rssi,
    input  ser_cfg_t         cfg,
    input  logic             alt_sel,
    output logic [PAY_W-1:0] payload,
    output logic [NB_W-1:0]  n_bytes
);
    always_comb begin
        logic [7:0] g0;
        logic [7:0] g1;
        int nb;
        if (cfg.gain_alt) begin
            g0 = alt_sel ? rssi : atten;
            g1 = 8'h00;
        end else begin
            g0 = atten;
            g1 = rssi;
        end
        if (!cfg.gain_en) begin
            g0 = 8'h00;
            g1 = 8'h00;
        end
        if (cfg.wide)
            payload = {i_word, q_word, g0, g1};
        else
            payload = {i_word[15:0], q_word[15:0], g0, g1, 16'h0000};
        nb = cfg.wide ? 6 : 4;
        if (cfg.gain_en)
            nb = nb + (cfg.gain_alt ? 1 : 2);
        n_bytes = NB_W'(nb);
    end
endmodule

// File: rtl/iq_ser_fsm.sv
module iq_ser_fsm
    import iq_ser_pkg::*;
#(
    parameter int GAP_BITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  ser_cfg_t         cfg_in,
    input  logic [PAY_W-1:0] payload,
    input  logic [NB_W-1:0]  n_bytes,
    input  logic             bit_end,
    output ser_state_e       state,
    output ser_cfg_t         cfg_q,
    output logic             data_raw,
    output logic             data_oe,
    output logic             fs_raw
);
    localparam int GAP_W = $clog2(GAP_BITS + 1);

    ser_state_e       state_d;
    logic [PAY_W-1:0] shreg;
    logic [NB_W-1:0]  bytes_left;
    logic [3:0]       slot;
    logic [GAP_W-1:0] gap_cnt;
    logic             last_slot;

    assign last_slot = (slot == (cfg_q.embed ? 4'd9 : 4'd7));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (start) state_d = cfg_in.embed ? ST_DATA : ST_SYNC;
            ST_SYNC: if (bit_end) state_d = ST_DATA;
            ST_DATA: if (bit_end && last_slot && bytes_left == NB_W'(1))
                         state_d = cfg_q.embed ? ST_GAP : ST_IDLE;
            ST_GAP:  if (bit_end && gap_cnt == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            shreg      <= '0;
            bytes_left <= '0;
            slot       <= '0;
            gap_cnt    <= '0;
        end else if (state == ST_IDLE && start) begin
            cfg_q      <= cfg_in;
            shreg      <= payload;
            bytes_left <= n_bytes;
            slot       <= '0;
            gap_cnt    <= GAP_W'(GAP_BITS - 1);
        end else if (state == ST_DATA && bit_end) begin
            if (!cfg_q.embed || (slot != 4'd0 && slot != 4'd9))
                shreg <= shreg << 1;
            if (last_slot) begin
                slot       <= '0;
                bytes_left <= bytes_left - NB_W'(1);
            end else begin
                slot <= slot + 4'd1;
            end
        end else if (state == ST_GAP && bit_end) begin
            gap_cnt <= gap_cnt - GAP_W'(1);
        end
    end

    // outputs
    always_comb begin
        data_raw = 1'b1;
        data_oe  = 1'b0;
        fs_raw   = 1'b0;
        unique case (state)
            ST_IDLE: data_oe = cfg_q.embed;
            ST_SYNC: fs_raw = 1'b1;
            ST_DATA: begin
                data_oe = 1'b1;
                fs_raw  = cfg_q.fs_long & ~cfg_q.embed;
                if (cfg_q.embed && slot == 4'd0)
                    data_raw = 1'b0;
                else if (cfg_q.embed && slot == 4'd9)
                    data_raw = 1'b1;
                else
                    data_raw = shreg[PAY_W-1];
            end
            ST_GAP:  data_oe = 1'b1;
            default: data_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/iq_serial_tx.sv
module iq_serial_tx
    import iq_ser_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int GAP_BITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_i,
    input  logic [SMP_W-1:0] smp_q,
    input  logic [7:0]       agc_atten,
    input  logic [7:0]       agc_rssi,
    input  logic             cfg_wide,
    input  logic             cfg_gain_en,
    input  logic             cfg_gain_alt,
    input  logic             cfg_embed_sync,
    input  logic             cfg_clk_inv,
    input  logic             cfg_fs_inv,
    input  logic             cfg_fs_long,
    input  logic             cfg_fs_hiz,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             ser_clk,
    output logic             ser_data,
    output logic             ser_data_oe,
    output logic             ser_fs,
    output logic             ser_fs_oe,
    output logic             overrun
);
    ser_cfg_t         cfg_in;
    ser_cfg_t         cfg_q;
    ser_state_e       fsm_state;
    logic [PAY_W-1:0] payload;
    logic [NB_W-1:0]  n_bytes;
    logic [DIV_W-1:0] div_q;
    logic             accept;
    logic             alt_sel;
    logic             bit_end;
    logic             clk_hi;
    logic             data_raw;
    logic             data_oe;
    logic             fs_raw;

    assign cfg_in = '{wide: cfg_wide, gain_en: cfg_gain_en, gain_alt: cfg_gain_alt,
                      embed: cfg_embed_sync, clk_inv: cfg_clk_inv, fs_inv: cfg_fs_inv,
                      fs_long: cfg_fs_long, fs_hiz: cfg_fs_hiz};
    assign accept = smp_valid && (fsm_state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(1);
            alt_sel <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (accept) begin
                div_q <= cfg_div;
                if (cfg_gain_en && cfg_gain_alt)
                    alt_sel <= ~alt_sel;
            end
            if (smp_valid && fsm_state != ST_IDLE)
                overrun <= 1'b1;
        end
    end

    iq_ser_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .div     (div_q),
        .bit_end (bit_end),
        .clk_hi  (clk_hi)
    );

    iq_ser_pack pack_i (
        .i_word  (smp_i),
        .q_word  (smp_q),
        .atten   (agc_atten),
        .rssi    (agc_rssi),
        .cfg     (cfg_in),
        .alt_sel (alt_sel),
        .payload (payload),
        .n_bytes (n_bytes)
    );

    iq_ser_fsm #(.GAP_BITS(GAP_BITS)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .cfg_in   (cfg_in),
        .payload  (payload),
        .n_bytes  (n_bytes),
        .bit_end  (bit_end),
        .state    (fsm_state),
        .cfg_q    (cfg_q),
        .data_raw (data_raw),
        .data_oe  (data_oe),
        .fs_raw   (fs_raw)
    );

    assign ser_clk     = clk_hi ^ cfg_q.clk_inv;
    assign ser_data    = data_raw;
    assign ser_data_oe = data_oe;
    assign ser_fs      = cfg_q.embed ? 1'b0 : (fs_raw ^ cfg_q.fs_inv);
    assign ser_fs_oe   = !(cfg_q.embed && cfg_q.fs_hiz);
endmodule

// File: rtl/iq_serial_tx_chk.sv
module iq_serial_tx_chk
    import iq_ser_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             overrun,
    input logic             bit_end,
    input ser_state_e       fsm_state,
    input ser_cfg_t         cfg_q,
    input logic [DIV_W-1:0] div_q
);
    p_drop_sets_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && fsm_state != ST_IDLE |=> overrun);

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(smp_valid));

    p_accept_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && fsm_state == ST_IDLE |=> fsm_state != ST_IDLE);

    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_IDLE && $past(fsm_state) != ST_IDLE) |-> ($stable(cfg_q) && $stable(div_q)));

    p_sync_one_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_SYNC && bit_end |=> fsm_state == ST_DATA);

    p_no_sync_embedded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.embed |-> fsm_state != ST_SYNC);

    p_reset_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !overrun);
endmodule

bind iq_serial_tx iq_serial_tx_chk #(.DIV_W(DIV_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .overrun   (overrun),
    .bit_end   (bit_end),
    .fsm_state (fsm_state),
    .cfg_q     (cfg_q),
    .div_q     (div_q)
);

// File: tb/iq_serial_tx_tb.sv
module iq_serial_tx_tb_top;
    typedef struct packed {
        logic       wide, gen, galt, emb, cinv, finv, flong, fhiz;
        logic [7:0] div;
        logic [23:0] i, q;
        logic [7:0] a, r;
        logic [7:0] nper;
    } vec_t;

    localparam int NV = 13;
    // nper: dedicated = payload bits (sync period added by bench); embedded = full frame periods
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd1, 24'h12A5C3, 24'h3C0F96, 8'hE1, 8'h4B, 8'd32},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd2, 24'h00B00B, 24'h7FFF01, 8'h81, 8'h18, 8'd48},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd1, 24'h0F0F0F, 24'hF0F0F0, 8'hAA, 8'h55, 8'd40},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd1, 24'h5A5A5A, 24'h0000FF, 8'hC3, 8'h3C, 8'd40},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd3, 24'hA5C3E1, 24'h1E3C5A, 8'h00, 8'hFF, 8'd48},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 8'd1, 24'h800001, 24'h7FFFFE, 8'h96, 8'h69, 8'd64},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0, 24'hDEADBE, 24'hCAFE01, 8'h0F, 8'hF0, 8'd56},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd1, 24'h00C001, 24'h00800F, 8'h11, 8'h22, 8'd49},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd2, 24'h00ABCD, 24'h001234, 8'h5C, 8'hA3, 8'd69},
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'd1, 24'h00FEDC, 24'h000101, 8'h77, 8'h88, 8'd59},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd1, 24'h123456, 24'h654321, 8'h01, 8'h02, 8'd69},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'd1, 24'hF00F0F, 24'h0FF0F0, 8'hB4, 8'h4B, 8'd89},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'd2, 24'h3C3C3C, 24'hC3C3C3, 8'hE7, 8'h18, 8'd79}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [23:0] smp_i = '0, smp_q = '0;
    logic [7:0] agc_atten = '0, agc_rssi = '0;
    logic cfg_wide = 0, cfg_gain_en = 0, cfg_gain_alt = 0, cfg_embed_sync = 0;
    logic cfg_clk_inv = 0, cfg_fs_inv = 0, cfg_fs_long = 0, cfg_fs_hiz = 0;
    logic [7:0] cfg_div = 8'd1;
    logic ser_clk, ser_data, ser_data_oe, ser_fs, ser_fs_oe, overrun;

    int nchk = 0;
    int nfail = 0;
    bit alt_flag = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    iq_serial_tx dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .agc_atten(agc_atten), .agc_rssi(agc_rssi), .cfg_wide(cfg_wide),
        .cfg_gain_en(cfg_gain_en), .cfg_gain_alt(cfg_gain_alt), .cfg_embed_sync(cfg_embed_sync),
        .cfg_clk_inv(cfg_clk_inv), .cfg_fs_inv(cfg_fs_inv), .cfg_fs_long(cfg_fs_long),
        .cfg_fs_hiz(cfg_fs_hiz), .cfg_div(cfg_div), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_data_oe(ser_data_oe), .ser_fs(ser_fs), .ser_fs_oe(ser_fs_oe), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic run_vec(input vec_t v, input bit inject);
        int d, nb, np, bad_d, bad_f, bad_c;
        logic [63:0] pl;
        string tag;
        d  = (v.div == 0) ? 1 : int'(v.div);
        pl = v.wide ? {v.i, v.q, 16'h0} : {v.i[15:0], v.q[15:0], 32'h0};
        nb = v.wide ? 6 : 4;
        if (v.gen) begin
            if (v.galt) begin
                pl[63-8*nb -: 8] = alt_flag ? v.r : v.a;
                nb = nb + 1;
                alt_flag = ~alt_flag;
            end else begin
                pl[63-8*nb -: 8] = v.a;
                pl[55-8*nb -: 8] = v.r;
                nb = nb + 2;
            end
        end
        np = v.emb ? int'(v.nper) : int'(v.nper) + 1;
        tag = v.emb ? "R6" : (v.gen ? (v.galt ? "R3" : "R2") : "R1");
        bad_d = 0; bad_f = 0; bad_c = 0;
        // present the sample
        smp_i = v.i; smp_q = v.q; agc_atten = v.a; agc_rssi = v.r;
        cfg_wide = v.wide; cfg_gain_en = v.gen; cfg_gain_alt = v.galt; cfg_embed_sync = v.emb;
        cfg_clk_inv = v.cinv; cfg_fs_inv = v.finv; cfg_fs_long = v.flong; cfg_fs_hiz = v.fhiz;
        cfg_div = v.div;
        smp_valid = 1'b1;
        @(posedge clk);
        #1;
        smp_valid = 1'b0;
        // R11: scramble everything after acceptance
        smp_i = ~v.i; smp_q = ~v.q; agc_atten = ~v.a; agc_rssi = ~v.r;
        cfg_wide = ~v.wide; cfg_gain_en = ~v.gen; cfg_gain_alt = ~v.galt; cfg_embed_sync = ~v.emb;
        cfg_clk_inv = ~v.cinv; cfg_fs_inv = ~v.finv; cfg_fs_long = ~v.flong; cfg_fs_hiz = ~v.fhiz;
        cfg_div = 8'd7;
        for (int p = 0; p < np; p++) begin
            logic ed, eoe, efs, efsoe;
            @(negedge clk);
            if (v.emb) begin
                int b, s;
                b = p / 10; s = p % 10;
                eoe = 1'b1; efs = 1'b0; efsoe = ~v.fhiz;
                if (b >= nb)      ed = 1'b1;
                else if (s == 0)  ed = 1'b0;
                else if (s == 9)  ed = 1'b1;
                else              ed = pl[63 - 8*b - (s-1)];
            end else begin
                efsoe = 1'b1;
                if (p == 0) begin
                    eoe = 1'b0; ed = 1'b1; efs = 1'b1 ^ v.finv;
                end else begin
                    eoe = 1'b1; ed = pl[63 - (p-1)]; efs = v.flong ^ v.finv;
                end
            end
            if (ser_data_oe !== eoe || (eoe && ser_data !== ed)) bad_d++;
            if (ser_fs !== efs || ser_fs_oe !== efsoe) bad_f++;
            if (ser_clk !== ~v.cinv) bad_c++;
            if (inject && p == 3) begin
                smp_valid = 1'b1;
                smp_i = 24'h13579B;
            end
            for (int k = 1; k < 2*d; k++) begin
                @(negedge clk);
                if (k == 1) smp_valid = 1'b0;
                if (k == d && ser_clk !== v.cinv) bad_c++;
            end
        end
        check(bad_d == 0, {tag, " R11 data stream"}, bad_d, 0);
        check(bad_f == 0, v.emb ? "R7 sync pin" : (v.flong ? "R5 R9 sync pin" : "R4 R9 sync pin"), bad_f, 0);
        check(bad_c == 0, "R8 R9 bit clock", bad_c, 0);
        // idle after the stated frame length
        @(negedge clk);
        if (v.emb)
            check(ser_data_oe === 1'b1 && ser_data === 1'b1, "R6 idle high", {ser_data_oe, ser_data}, 3);
        else
            check(ser_data_oe === 1'b0 && ser_fs === v.finv, "R4 idle released", {ser_data_oe, ser_fs}, {1'b0, v.finv});
        check(overrun === inject, "R10 overrun", overrun, inject);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(overrun === 1'b0 && ser_data_oe === 1'b0 && ser_fs === 1'b0 && ser_fs_oe === 1'b1,
              "R12 reset state", {overrun, ser_data_oe, ser_fs, ser_fs_oe}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int n = 0; n < NV; n++)
            run_vec(VECS[n], 1'b0);
        // R10: sample dropped mid-frame, frame intact
        run_vec(VECS[0], 1'b1);
        // R12: reset clears the sticky flag and the alternation phase
        rst_n = 1'b0;
        alt_flag = 1'b0;
        repeat (3) @(negedge clk);
        check(overrun === 1'b0 && ser_data_oe === 1'b0 && ser_fs === 1'b0 && ser_fs_oe === 1'b1,
              "R12 reset after overrun", {overrun, ser_data_oe, ser_fs, ser_fs_oe}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        run_vec(VECS[2], 1'b0);
        report();
    end
endmodule